// File: doc/BRIEF.md
# SCSI Controller Host Register Front End

This block is the byte-wide host side of a SCSI bus controller. The host sees two ports. Through the address port it writes a pointer that selects one of 32 internal byte registers, and it reads the auxiliary status byte. Through the data port it reads or writes the register the pointer selects. After every data-port write the pointer moves to the next register, so the host can fill neighbouring registers, such as the three byte-count registers, in one burst. The block also holds the interrupt-pending flag and drives a registered interrupt request from it.

A small command decoder acts on bytes written to the command register. A reset command posts a reset-complete status. A select-with-attention command posts either a selection timeout or a phase change into the command phase. The outcome depends on whether a target answers at the addressed ID, which the `tgtPresent` input models. A transfer-info command loads a 24-bit byte count and then takes data-register writes until the count is used up. The last byte posts a transfer-complete status carrying the data direction that the `tgtDataOut` input reports. The bus signalling, DMA, parity and the target itself are outside this block.

Register indices: 0 own-ID, 1 control, 2 count high, 3 count middle, 4 count low, 5 destination ID, 6 command-status, 7 command, 8 data. All other indices are plain storage.

Top module: `scsi_regfront`

## Requirements
- R1: After synchronous reset, all 32 registers, the pointer, the pending flag, `irqOut` and `xferErr` are zero. An auxiliary status read then returns 0x01.
- R2: A write to the address port (`hostSel`=0) loads the pointer with the low 5 bits of the byte. A read of the address port returns the auxiliary status: bit 0 is always 1, bit 7 equals the pending flag, and all other bits are 0.
- R3: A data-port write (`hostSel`=1) stores the byte in the selected register and then increments the pointer by one, wrapping from 31 to 0.
- R4: A data-port read returns the selected register and leaves the pointer unchanged. Reading register 6 clears the pending flag. Reading any other register leaves the flag unchanged.
- R5: Writing register 1 with bit 3 set clears the pending flag. Writing it with bit 3 clear leaves the flag unchanged.
- R6: Command code 0x00 (reset) sets register 6 to 0x01 and sets the pending flag.
- R7: Command code 0x06 (select with attention) sets the pending flag. If `tgtPresent` has a 0 at the ID held in bits 2:0 of register 5, register 6 becomes 0x42 (timeout). If that bit is 1, register 6 becomes 0x8A (phase change, command phase).
- R8: Command code 0x20 (transfer info) loads the remaining count with {reg2, reg3, reg4}, most significant byte first, and clears the pending flag.
- R9: While the remaining count is nonzero, each write to register 8 stores the byte and decrements the count. The write that brings the count to zero sets the pending flag and sets register 6 to 0x10 if `tgtDataOut` is 1 (data out) or to 0x11 if it is 0 (data in).
- R10: Bit 7 of a command byte is ignored when the command is decoded. For example, 0x86 acts as 0x06.
- R11: A write to register 8 while the remaining count is zero leaves register 8 unchanged and sets `xferErr`. `xferErr` stays set until reset.
- R12: `irqOut` equals the pending flag delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostSel | input | 1 | 0 selects the address/status port, 1 selects the data port |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access (ignored while hostWr is high) |
| hostWData | input | 8 | Host write byte |
| hostRData | output | 8 | Host read byte for the current `hostSel` |
| tgtPresent | input | 8 | One bit per target ID: a 1 means a target answers selection |
| tgtDataOut | input | 1 | Target direction for a finished transfer: 1 = data out, 0 = data in |
| irqOut | output | 1 | Registered interrupt request |
| xferErr | output | 1 | Sticky flag for a data byte written after the count ran out |

## Verification
The bench fills the three count registers in one auto-incrementing burst and runs a count whose bytes are not symmetric (0x000102). A design that joined the count bytes in the wrong order would raise the interrupt after the wrong number of bytes. It also writes register 31 to check the pointer wrap-around: a design that did not wrap, or that masked the address wrongly, would read back the wrong register. It checks that status reads of registers other than command-status leave the interrupt set, and that a control write without the clear bit also leaves it set; a design that cleared on any access fails these checks. It also checks that a command with bit 7 set still decodes, and that a data byte written after the count ran out is not stored and latches the error flag.

// File: rtl/scsi_regfront_pkg.sv
package scsi_regfront_pkg;

  // register indices that the decoder acts on
  localparam int IdxOwnId   = 0;
  localparam int IdxCtrl    = 1;
  localparam int IdxCntHi   = 2;
  localparam int IdxCntMid  = 3;
  localparam int IdxCntLo   = 4;
  localparam int IdxDestId  = 5;
  localparam int IdxStat    = 6;
  localparam int IdxCmd     = 7;
  localparam int IdxData    = 8;

  // control register bit that clears the pending interrupt
  localparam int CtrlClrBit = 3;

  // command codes (bit 7 is the single-byte flag, ignored on decode)
  localparam logic [6:0] CmdReset    = 7'h00;
  localparam logic [6:0] CmdSelAtn   = 7'h06;
  localparam logic [6:0] CmdXferInfo = 7'h20;

  // status codes
  localparam logic [7:0] StatResetDone  = 8'h01;
  localparam logic [7:0] StatSelTimeout = 8'h42;
  localparam logic [7:0] StatPhaseChg   = 8'h88;
  localparam logic [7:0] StatXferDone   = 8'h10;

  // bus phase codes merged into the status
  localparam logic [7:0] PhaseDataOut = 8'h00;
  localparam logic [7:0] PhaseDataIn  = 8'h01;
  localparam logic [7:0] PhaseCmd     = 8'h02;

  // strobes from control to datapath
  typedef struct packed {
    logic       regWr;    // store host byte at pointer
    logic       statWr;   // load status register
    logic [7:0] statVal;  // value for status register
  } dpStrobe_t;

endpackage

// File: rtl/scsi_regfront_ctrl.sv
module scsi_regfront_ctrl
  import scsi_regfront_pkg::*;
#(
  parameter int RegCount   = 32,
  parameter int NumTargets = 8,
  localparam int RegIdxW   = $clog2(RegCount),
  localparam int TgtIdW    = $clog2(NumTargets),
  localparam int CountW    = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hostSel,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic [7:0]            hostWData,
  input  logic [7:0]            cntHi,
  input  logic [7:0]            cntMid,
  input  logic [7:0]            cntLo,
  input  logic [7:0]            destId,
  input  logic [NumTargets-1:0] tgtPresent,
  input  logic                  tgtDataOut,
  output dpStrobe_t             strb,
  output logic [RegIdxW-1:0]    regPtr,
  output logic                  pendQ,
  output logic                  irqQ,
  output logic                  errQ
);

  logic [RegIdxW-1:0] ptrNext;
  logic [CountW-1:0]  remQ, remNext;
  logic               pendNext, errNext;
  logic               addrWr, dataWr, dataRd;
  logic [TgtIdW-1:0]  tgtSel;

  assign addrWr = hostWr && !hostSel;
  assign dataWr = hostWr && hostSel;
  assign dataRd = hostRd && hostSel && !hostWr;
  assign tgtSel = destId[TgtIdW-1:0];

  // pointer: load on address write, step on data write
  always_comb begin
    ptrNext = regPtr;
    if (addrWr) begin
      ptrNext = hostWData[RegIdxW-1:0];
    end else if (dataWr) begin
      ptrNext = regPtr + 1'b1;
    end
  end

  // command decode, transfer counting, interrupt flag
  always_comb begin
    strb         = '0;
    strb.regWr   = dataWr;
    pendNext     = pendQ;
    remNext      = remQ;
    errNext      = errQ;
    if (dataWr) begin
      if (regPtr == RegIdxW'(IdxCtrl)) begin
        if (hostWData[CtrlClrBit]) begin
          pendNext = 1'b0;
        end
      end else if (regPtr == RegIdxW'(IdxCmd)) begin
        case (hostWData[6:0])
          CmdReset: begin
            strb.statWr  = 1'b1;
            strb.statVal = StatResetDone;
            pendNext     = 1'b1;
          end
          CmdSelAtn: begin
            strb.statWr  = 1'b1;
            strb.statVal = tgtPresent[tgtSel] ? (StatPhaseChg | PhaseCmd)
                                              : StatSelTimeout;
            pendNext     = 1'b1;
          end
          CmdXferInfo: begin
            remNext  = {cntHi, cntMid, cntLo};
            pendNext = 1'b0;
          end
          default: ;
        endcase
      end else if (regPtr == RegIdxW'(IdxData)) begin
        if (remQ == '0) begin
          strb.regWr = 1'b0;
          errNext    = 1'b1;
        end else begin
          remNext = remQ - 1'b1;
          if (remQ == CountW'(1)) begin
            strb.statWr  = 1'b1;
            strb.statVal = StatXferDone | (tgtDataOut ? PhaseDataOut : PhaseDataIn);
            pendNext     = 1'b1;
          end
        end
      end
    end else if (dataRd && regPtr == RegIdxW'(IdxStat)) begin
      pendNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regPtr <= '0;
      remQ   <= '0;
      pendQ  <= 1'b0;
      irqQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      regPtr <= ptrNext;
      remQ   <= remNext;
      pendQ  <= pendNext;
      irqQ   <= pendQ;
      errQ   <= errNext;
    end
  end

endmodule

// File: rtl/scsi_regfront_dp.sv
module scsi_regfront_dp
  import scsi_regfront_pkg::*;
#(
  parameter int RegCount = 32,
  localparam int RegIdxW = $clog2(RegCount)
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          strb,
  input  logic [RegIdxW-1:0] regPtr,
  input  logic               hostSel,
  input  logic [7:0]         hostWData,
  input  logic               pendQ,
  output logic [7:0]         hostRData,
  output logic [7:0]         cntHi,
  output logic [7:0]         cntMid,
  output logic [7:0]         cntLo,
  output logic [7:0]         destId
);

  logic [7:0] regs [RegCount];
  logic [7:0] auxByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RegCount; i++) begin
        regs[i] <= '0;
      end
    end else begin
      if (strb.regWr) begin
        regs[regPtr] <= hostWData;
      end
      if (strb.statWr) begin
        regs[IdxStat] <= strb.statVal;
      end
    end
  end

  assign auxByte   = {pendQ, 6'b0, 1'b1};
  assign hostRData = hostSel ? regs[regPtr] : auxByte;
  assign cntHi     = regs[IdxCntHi];
  assign cntMid    = regs[IdxCntMid];
  assign cntLo     = regs[IdxCntLo];
  assign destId    = regs[IdxDestId];

endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
  import scsi_regfront_pkg::*;
#(
  parameter int RegCount   = 32,
  parameter int NumTargets = 8,
  localparam int RegIdxW   = $clog2(RegCount)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hostSel,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic [7:0]            hostWData,
  output logic [7:0]            hostRData,
  input  logic [NumTargets-1:0] tgtPresent,
  input  logic                  tgtDataOut,
  output logic                  irqOut,
  output logic                  xferErr
);

  dpStrobe_t          strb;
  logic [RegIdxW-1:0] regPtr;
  logic               pendQ;
  logic [7:0]         cntHi, cntMid, cntLo, destId;

  scsi_regfront_ctrl #(
    .RegCount   (RegCount),
    .NumTargets (NumTargets)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostWData  (hostWData),
    .cntHi      (cntHi),
    .cntMid     (cntMid),
    .cntLo      (cntLo),
    .destId     (destId),
    .tgtPresent (tgtPresent),
    .tgtDataOut (tgtDataOut),
    .strb       (strb),
    .regPtr     (regPtr),
    .pendQ      (pendQ),
    .irqQ       (irqOut),
    .errQ       (xferErr)
  );

  scsi_regfront_dp #(
    .RegCount (RegCount)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .regPtr    (regPtr),
    .hostSel   (hostSel),
    .hostWData (hostWData),
    .pendQ     (pendQ),
    .hostRData (hostRData),
    .cntHi     (cntHi),
    .cntMid    (cntMid),
    .cntLo     (cntLo),
    .destId    (destId)
  );

endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk #(
  parameter int RegIdxW = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               hostSel,
  input logic               hostWr,
  input logic               hostRd,
  input logic [7:0]         hostWData,
  input logic [7:0]         hostRData,
  input logic               irqOut,
  input logic               xferErr,
  input logic [RegIdxW-1:0] regPtr,
  input logic               pendQ
);

  // R2
  aux_status_chk: assert property (@(posedge clk) disable iff (rst)
    !hostSel |-> (hostRData == {pendQ, 7'h01}));

  // R2
  addr_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (hostWr && !hostSel) |=> (regPtr == $past(hostWData[RegIdxW-1:0])));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hostWr && hostSel) |=> (regPtr == RegIdxW'($past(regPtr) + 1'b1)));

  // R4
  ptr_hold_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr) |=> $stable(regPtr));

  // R4
  stat_rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr && hostSel && regPtr == RegIdxW'(6)) |=> !pendQ);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    xferErr |=> xferErr);

  // R12
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(pendQ)));

endmodule

bind scsi_regfront scsi_regfront_chk #(.RegIdxW(RegIdxW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hostSel   (hostSel),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostWData (hostWData),
  .hostRData (hostRData),
  .irqOut    (irqOut),
  .xferErr   (xferErr),
  .regPtr    (regPtr),
  .pendQ     (pendQ)
);

// File: tb/scsi_regfront_bench.sv
module scsi_regfront_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hostSel = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostWData = 8'h00;
  logic [7:0] hostRData;
  logic [7:0] tgtPresent = 8'h00;
  logic       tgtDataOut = 1'b0;
  logic       irqOut;
  logic       xferErr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scsi_regfront u_scsi_regfront (
    .clk        (clk),
    .rst        (rst),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostWData  (hostWData),
    .hostRData  (hostRData),
    .tgtPresent (tgtPresent),
    .tgtDataOut (tgtDataOut),
    .irqOut     (irqOut),
    .xferErr    (xferErr)
  );

  // vector: {isRead, sel, data, expected}
  localparam int NumVec = 16;
  localparam logic [17:0] vecTab [NumVec] = '{
    {1'b0, 1'b0, 8'h00, 8'h00},   // ptr 0
    {1'b0, 1'b1, 8'h55, 8'h00},   // reg0 = 55, ptr 1
    {1'b0, 1'b1, 8'h00, 8'h00},   // reg1 = 00, ptr 2
    {1'b0, 1'b0, 8'h20, 8'h00},   // masked to ptr 0
    {1'b1, 1'b1, 8'h00, 8'h55},   // read reg0
    {1'b0, 1'b0, 8'h1F, 8'h00},   // ptr 31
    {1'b0, 1'b1, 8'hA5, 8'h00},   // reg31 = A5, ptr wraps 0
    {1'b1, 1'b1, 8'h00, 8'h55},   // read reg0 after wrap
    {1'b0, 1'b0, 8'h07, 8'h00},   // ptr 7
    {1'b0, 1'b1, 8'h00, 8'h00},   // reset command
    {1'b1, 1'b0, 8'h00, 8'h81},   // aux shows pending
    {1'b0, 1'b0, 8'h06, 8'h00},   // ptr 6
    {1'b1, 1'b1, 8'h00, 8'h01},   // status reset-done, clears
    {1'b1, 1'b0, 8'h00, 8'h01},   // aux pending gone
    {1'b0, 1'b0, 8'h1F, 8'h00},   // ptr 31
    {1'b1, 1'b1, 8'h00, 8'hA5}    // read reg31
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic putAddr(input logic [7:0] v);
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b1; hostWData = v;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic putData(input logic [7:0] v);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostWData = v;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic getPort(input logic sel, output logic [7:0] v);
    @(negedge clk);
    hostSel = sel; hostRd = 1'b1;
    #1 v = hostRData;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic putReg(input logic [7:0] idx, input logic [7:0] v);
    putAddr(idx);
    putData(v);
  endtask

  task automatic getReg(input logic [7:0] idx, output logic [7:0] v);
    putAddr(idx);
    getPort(1'b1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    #1;
    chk("R1 irqOut", {7'b0, irqOut}, 8'h00);
    chk("R1 xferErr", {7'b0, xferErr}, 8'h00);
    getPort(1'b0, v);      chk("R1 aux", v, 8'h01);
    getPort(1'b1, v);      chk("R1 reg0", v, 8'h00);
    getReg(8'd6, v);       chk("R1 status", v, 8'h00);

    // table walk: R2 R3 R4 R6
    for (int i = 0; i < NumVec; i++) begin
      if (vecTab[i][17]) begin
        getPort(vecTab[i][16], v);
        chk($sformatf("R2_R3_R4_R6 table step %0d", i), v, vecTab[i][7:0]);
      end else if (vecTab[i][16]) begin
        putData(vecTab[i][15:8]);
      end else begin
        putAddr(vecTab[i][15:8]);
      end
    end

    // R12: irqOut lags the flag by one clock
    putAddr(8'd7);
    putData(8'h00);
    chk("R12 irqOut before", {7'b0, irqOut}, 8'h00);
    @(negedge clk);
    chk("R12 irqOut after", {7'b0, irqOut}, 8'h01);

    // R4: reading a non-status register keeps the flag
    getReg(8'd0, v);
    getPort(1'b0, v);      chk("R4 other read keeps", v, 8'h81);

    // R5: control write without / with clear bit
    putReg(8'd1, 8'h04);
    getPort(1'b0, v);      chk("R5 no clear bit", v, 8'h81);
    putReg(8'd1, 8'h08);
    getPort(1'b0, v);      chk("R5 clear bit", v, 8'h01);

    // R7: select with attention, target absent at ID 3
    tgtPresent = 8'b0000_0100;
    putReg(8'd5, 8'h03);
    putReg(8'd7, 8'h06);
    getPort(1'b0, v);      chk("R7 timeout pending", v, 8'h81);
    getReg(8'd6, v);       chk("R7 timeout status", v, 8'h42);

    // R10 and R7: bit 7 set, target present at ID 2 (dest 0xFA)
    putReg(8'd5, 8'hFA);
    putReg(8'd7, 8'h86);
    getReg(8'd6, v);       chk("R10 R7 phase change", v, 8'h8A);

    // R8 R9: count 3, data-in
    putReg(8'd7, 8'h00);   // raise flag so the clear is visible
    putAddr(8'd2);
    putData(8'h00); putData(8'h00); putData(8'h03);
    putReg(8'd7, 8'h20);
    getPort(1'b0, v);      chk("R8 xfer clears flag", v, 8'h01);
    tgtDataOut = 1'b0;
    putReg(8'd8, 8'h11);
    putReg(8'd8, 8'h22);
    getPort(1'b0, v);      chk("R9 not yet done", v, 8'h01);
    putReg(8'd8, 8'h33);
    getPort(1'b0, v);      chk("R9 done pending", v, 8'h81);
    getReg(8'd6, v);       chk("R9 data-in status", v, 8'h11);

    // R11: byte after count used up
    putReg(8'd8, 8'h44);
    chk("R11 err set", {7'b0, xferErr}, 8'h01);
    getReg(8'd8, v);       chk("R11 data kept", v, 8'h33);
    getPort(1'b0, v);      chk("R11 no irq", v, 8'h01);
    putReg(8'd0, 8'h77);
    chk("R11 err sticky", {7'b0, xferErr}, 8'h01);

    // R8 R9: count 0x000102 = 258 bytes, data-out
    putAddr(8'd2);
    putData(8'h00); putData(8'h01); putData(8'h02);
    putReg(8'd7, 8'h20);
    tgtDataOut = 1'b1;
    for (int n = 0; n < 257; n++) begin
      putReg(8'd8, 8'(n));
    end
    getPort(1'b0, v);      chk("R8 byte order 257", v, 8'h01);
    putReg(8'd8, 8'hEE);
    getPort(1'b0, v);      chk("R8 byte order 258", v, 8'h81);
    getReg(8'd6, v);       chk("R9 data-out status", v, 8'h10);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 err after reset", {7'b0, xferErr}, 8'h00);
    getReg(8'd8, v);       chk("R1 data after reset", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule